// File: doc/BRIEF.md
# Working-Set Signature Collector

This block condenses the instruction-cache lines a program touches into a fixed-width bit-vector fingerprint, one fingerprint per interval of retired instructions. Each valid fetch address is reduced to its cache-line address. A cheap hash folds that line address onto one bit position, and the block sets that bit. Two fingerprints taken at different times can then be compared downstream to decide whether the program is in a familiar phase of execution.

The block counts retired instructions against a fixed interval length. It records fetches only near the end of the interval, during the final tenth, which keeps the number of vector writes small. When the count reaches the interval length, the block raises a one-cycle end pulse. It then freezes the fingerprint and presents it as valid until a clear request empties the vector and starts the next interval.

Top module: `wss_collector`

## Requirements
- R1: After reset, `signature` is all zeros and both `sig_valid` and `interval_end` are low.
- R2: A recorded fetch sets exactly one bit of `signature`. With the default 32-byte lines and 128 bits, the index is `fetch_pc[11:5] ^ fetch_pc[18:12]`: the lowest 7 bits of the line address XOR the next 7 bits.
- R3: A fetch is recorded only if the registered instruction count at that cycle is at least `INTERVAL_LEN - INTERVAL_LEN/10`. The registered count excludes the current cycle's `retire_cnt`. Earlier fetches leave `signature` unchanged.
- R4: `interval_end` is high for exactly one cycle: the first cycle after a `retire_cnt` brings the count to `INTERVAL_LEN` or beyond. `sig_valid` rises in that same cycle.
- R5: While `sig_valid` is high and no clear is requested, fetches and retires have no effect. `signature` stays stable, `sig_valid` stays high and `interval_end` stays low.
- R6: A `clear_sig` cycle gives, from the next cycle on, an all-zero `signature`, a count of zero and a low `sig_valid`. A fetch or retire in the same cycle as `clear_sig` is discarded.
- R7: Recorded bits accumulate by OR within an interval. A fetch to a line whose bit is already set changes nothing.
- R8: `retire_cnt` adds 0 to 3 instructions per cycle. A step that passes `INTERVAL_LEN` ends the interval just as an exact hit does, and the excess is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | PC_W | Byte address of the fetch |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| clear_sig | input | 1 | Empty the vector and restart the interval |
| signature | output | SIG_BITS | Working-set fingerprint |
| sig_valid | output | 1 | Interval complete, fingerprint frozen |
| interval_end | output | 1 | One-cycle pulse at interval completion |

## Verification
The bench builds the block with `INTERVAL_LEN` = 20 and keeps every other parameter at its default. This makes the recording window two counts wide (18 and 19), so the window boundary, completion by overshoot and the frozen state are each reached many times in a few thousand cycles. Random clears land in the early phase, in the window and in the frozen state, so clear priority is exercised against every phase.

// File: rtl/wss_pkg.sv
package wss_pkg;
    typedef enum logic [1:0] {
        PH_EARLY  = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_HELD   = 2'd2
    } wss_phase_e;
endpackage

// File: rtl/wss_line_hash.sv
module wss_line_hash #(
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 32,
    parameter int SIG_BITS   = 128
) (
    input  logic [PC_W-1:0]             pc,
    output logic [$clog2(SIG_BITS)-1:0] idx
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SIG_BITS);

    logic [IDX_W-1:0] slice_lo;
    logic [IDX_W-1:0] slice_hi;
    logic             unused_pc_bits;

    assign slice_lo = pc[OFF_W +: IDX_W];
    assign slice_hi = pc[OFF_W + IDX_W +: IDX_W];
    assign idx      = slice_lo ^ slice_hi;
    assign unused_pc_bits = ^{pc[OFF_W-1:0], pc[PC_W-1:OFF_W + 2*IDX_W]};
endmodule

// File: rtl/wss_interval_ctr.sv
module wss_interval_ctr
    import wss_pkg::*;
#(
    parameter int INTERVAL_LEN = 100000,
    parameter int RET_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [RET_W-1:0] ret_inc,
    output wss_phase_e       phase,
    output logic             end_pulse
);
    localparam int CNT_W     = $clog2(INTERVAL_LEN + 1);
    localparam int WIN_START = INTERVAL_LEN - INTERVAL_LEN / 10;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ended;
    } ctr_s;

    ctr_s            st_d, st_q;
    logic [CNT_W:0]  sum;

    always_comb begin
        st_d       = st_q;
        st_d.ended = 1'b0;
        sum        = {1'b0, st_q.cnt} + (CNT_W+1)'(ret_inc);
        if (clr) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_W'(INTERVAL_LEN)) begin
            if (sum >= (CNT_W+1)'(INTERVAL_LEN)) begin
                st_d.cnt   = CNT_W'(INTERVAL_LEN);
                st_d.ended = 1'b1;
            end else begin
                st_d.cnt = sum[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.cnt == CNT_W'(INTERVAL_LEN))   phase = PH_HELD;
        else if (st_q.cnt >= CNT_W'(WIN_START)) phase = PH_SAMPLE;
        else                                    phase = PH_EARLY;
    end

    assign end_pulse = st_q.ended;
endmodule

// File: rtl/wss_sig_store.sv
module wss_sig_store #(
    parameter int SIG_BITS = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        set_en,
    input  logic [$clog2(SIG_BITS)-1:0] set_idx,
    output logic [SIG_BITS-1:0]         vec
);
    localparam int IDX_W = $clog2(SIG_BITS);

    logic [SIG_BITS-1:0] vec_d, vec_q;

    for (genvar g = 0; g < SIG_BITS; g++) begin : g_bit
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        always_comb begin
            if (clr) vec_d[g] = 1'b0;
            else     vec_d[g] = vec_q[g] | (set_en && (set_idx == MY_IDX));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign vec = vec_q;
endmodule

// File: rtl/wss_collector.sv
module wss_collector
    import wss_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int LINE_BYTES   = 32,
    parameter int SIG_BITS     = 128,
    parameter int INTERVAL_LEN = 100000,
    parameter int RET_W        = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid,
    input  logic [PC_W-1:0]     fetch_pc,
    input  logic [RET_W-1:0]    retire_cnt,
    input  logic                clear_sig,
    output logic [SIG_BITS-1:0] signature,
    output logic                sig_valid,
    output logic                interval_end
);
    localparam int IDX_W = $clog2(SIG_BITS);

    wss_phase_e       phase;
    logic [IDX_W-1:0] line_idx;
    logic             rec_en;

    wss_line_hash #(
        .PC_W       (PC_W),
        .LINE_BYTES (LINE_BYTES),
        .SIG_BITS   (SIG_BITS)
    ) u_hash (
        .pc  (fetch_pc),
        .idx (line_idx)
    );

    wss_interval_ctr #(
        .INTERVAL_LEN (INTERVAL_LEN),
        .RET_W        (RET_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clear_sig),
        .ret_inc   (retire_cnt),
        .phase     (phase),
        .end_pulse (interval_end)
    );

    assign rec_en = fetch_valid && (phase == PH_SAMPLE);

    wss_sig_store #(
        .SIG_BITS (SIG_BITS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clear_sig),
        .set_en  (rec_en),
        .set_idx (line_idx),
        .vec     (signature)
    );

    assign sig_valid = (phase == PH_HELD);
endmodule

// File: rtl/wss_collector_chk.sv
module wss_collector_chk
    import wss_pkg::*;
#(
    parameter int SIG_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clear_sig,
    input logic [SIG_BITS-1:0] signature,
    input logic                sig_valid,
    input logic                interval_end,
    input wss_phase_e          phase
);
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_sig |=> (signature == '0) && !sig_valid);

    assert_end_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end |=> !interval_end);

    assert_end_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end |-> sig_valid);

    assert_held_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_valid && !clear_sig) |=> $stable(signature) && sig_valid && !interval_end);

    assert_early_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EARLY && !clear_sig) |=> $stable(signature));

    assert_bits_accumulate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_sig |=> ((signature & $past(signature)) == $past(signature)));

    assert_one_new_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_sig |=> ($countones(signature) <= $countones($past(signature)) + 1));
endmodule

bind wss_collector wss_collector_chk #(.SIG_BITS(SIG_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_sig    (clear_sig),
    .signature    (signature),
    .sig_valid    (sig_valid),
    .interval_end (interval_end),
    .phase        (phase)
);

// File: tb/tb_wss_collector.sv
`timescale 1ns/1ps
module tb_wss_collector;
    localparam int LEN   = 20;
    localparam int START = LEN - LEN / 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_pc = '0;
    logic [1:0]   retire_cnt = '0;
    logic         clear_sig = 1'b0;
    logic [127:0] signature;
    logic         sig_valid;
    logic         interval_end;

    int unsigned  n_checks = 0;
    int unsigned  n_fail = 0;
    int           m_cnt = 0;
    logic [127:0] m_sig = '0;
    logic         m_end = 1'b0;

    always #2 clk = ~clk;

    wss_collector #(.INTERVAL_LEN(LEN)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_pc     (fetch_pc),
        .retire_cnt   (retire_cnt),
        .clear_sig    (clear_sig),
        .signature    (signature),
        .sig_valid    (sig_valid),
        .interval_end (interval_end)
    );

    function automatic int unsigned hidx(input logic [31:0] pc);
        return int'(pc[11:5] ^ pc[18:12]);
    endfunction

    task automatic check_outs(input string tag);
        n_checks++;
        if (signature !== m_sig) begin
            n_fail++;
            $display("FAIL %s signature got %h exp %h", tag, signature, m_sig);
        end
        n_checks++;
        if (sig_valid !== (m_cnt == LEN)) begin
            n_fail++;
            $display("FAIL %s sig_valid got %b exp %b", tag, sig_valid, (m_cnt == LEN));
        end
        n_checks++;
        if (interval_end !== m_end) begin
            n_fail++;
            $display("FAIL %s interval_end got %b exp %b", tag, interval_end, m_end);
        end
    endtask

    task automatic step(input logic fv, input logic [31:0] pc, input logic [1:0] inc,
                        input logic clr, input string tag);
        fetch_valid = fv;
        fetch_pc    = pc;
        retire_cnt  = inc;
        clear_sig   = clr;
        @(posedge clk);
        m_end = 1'b0;
        if (clr) begin
            m_cnt = 0;
            m_sig = '0;
        end else if (m_cnt < LEN) begin
            if (fv && m_cnt >= START) m_sig[hidx(pc)] = 1'b1;
            if (m_cnt + int'(inc) >= LEN) begin
                m_cnt = LEN;
                m_end = 1'b1;
            end else begin
                m_cnt = m_cnt + int'(inc);
            end
        end
        @(negedge clk);
        check_outs(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check_outs("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1 after reset");

        // R3: early fetches ignored
        step(1'b1, 32'h0000_1040, 2'd0, 1'b0, "R3 early fetch");
        step(1'b1, 32'h0004_2fe0, 2'd3, 1'b0, "R3 early fetch");
        for (int i = 0; i < 4; i++) step(1'b0, '0, 2'd3, 1'b0, "R8 count up");
        step(1'b0, '0, 2'd2, 1'b0, "R8 count up");
        // count now 17: fetch here is one short of the window
        step(1'b1, 32'h0000_0060, 2'd1, 1'b0, "R3 window boundary");
        // count 18: first recorded fetch, line 2 -> bit 2
        step(1'b1, 32'h0000_0040, 2'd0, 1'b0, "R2 first sampled");
        n_checks++;
        if (signature !== 128'h4) begin
            n_fail++;
            $display("FAIL R2 hash bit got %h exp %h", signature, 128'h4);
        end
        step(1'b1, 32'h0000_0040, 2'd0, 1'b0, "R7 repeat line");
        step(1'b1, 32'h0003_f9a0, 2'd0, 1'b0, "R7 second line");
        step(1'b1, 32'hdead_beef, 2'd3, 1'b0, "R8 overshoot R4 end");
        step(1'b1, 32'h1234_5670, 2'd3, 1'b0, "R5 held R4 pulse drop");
        step(1'b1, 32'h0bad_cafe, 2'd2, 1'b0, "R5 held");
        step(1'b1, 32'h0000_0080, 2'd2, 1'b1, "R6 clear wins");
        // mid-interval clear inside the window
        for (int i = 0; i < 6; i++) step(1'b0, '0, 2'd3, 1'b0, "R8 count up");
        step(1'b1, 32'h0000_0fe0, 2'd0, 1'b0, "R2 sample");
        step(1'b1, 32'h0000_0c20, 2'd1, 1'b1, "R6 clear mid window");
        step(1'b1, 32'h0000_0c20, 2'd0, 1'b0, "R3 after clear");

        for (int i = 0; i < 4000; i++) begin
            logic        fv;
            logic [31:0] pc;
            logic [1:0]  inc;
            logic        clr;
            fv  = ($urandom % 2) == 0;
            pc  = $urandom;
            if (($urandom % 4) == 0) pc = {13'd0, 3'd0, pc[15:0]} & 32'h0000_01e0;
            inc = 2'($urandom % 4);
            clr = ($urandom % 30) == 0;
            step(fv, pc, inc, clr, "R2 R4 R5 R6 R7 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule